// File: doc/BRIEF.md
# Sample Rate Gauge

This block measures how fast one event stream runs compared with another when both are delivered as single-cycle enables in one master clock domain. One stream is the audio reference tick and the other is the baseband sample strobe. A free-running reference counter counts audio ticks and defines a fixed measurement window of 256 ticks. A separate free-running sample counter counts baseband strobes.

Whenever the reference counter rolls over, the running sample count is copied into a snapshot register, and a one-cycle valid pulse marks the update. The sample counter is never cleared. Software therefore subtracts successive snapshots, modulo 2^16, to get the number of samples per window and from that the frequency offset between the two clocks. The snapshot is read through a plain read port, and reading has no side effect.

Top module: `srg_top`

## Requirements
- R1: The reference counter is 8 bits wide and advances by one on each cycle with `ref_tick_i` high. It wraps freely from 255 to 0, so captures occur exactly once every 256 reference ticks.
- R2: The sample counter is 16 bits wide and advances by one on each cycle with `smp_tick_i` high. It wraps freely from 65535 to 0 and is never cleared except by reset.
- R3: On the clock edge where `ref_tick_i` is high while the reference counter holds 255, the snapshot register is loaded with the sample count. At all other edges the snapshot holds its value.
- R4: If `smp_tick_i` is also high in that rollover cycle, the captured value includes that sample, so it equals the post-edge sample count.
- R5: While `rd_en_i` is high, `rd_data_o[15:0]` shows the snapshot and `rd_data_o[31:16]` reads zero. While `rd_en_i` is low, `rd_data_o` is all zero.
- R6: `snap_valid_o` is high for exactly the one cycle after each snapshot update and low otherwise.
- R7: Asynchronous active-low reset `rst_n` clears both counters, the snapshot and the valid pulse to zero.
- R8: `rd_en_i` has no effect on either counter or on the snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick_i | input | 1 | Audio reference tick enable, one cycle per event |
| smp_tick_i | input | 1 | Baseband sample strobe, one cycle per event |
| rd_en_i | input | 1 | Read enable for the snapshot word |
| rd_data_o | output | 32 | Snapshot word; count in bits [15:0] |
| snap_valid_o | output | 1 | One-cycle pulse after each snapshot update |

## Verification
A reference counter that is off by even one tick shifts every later capture by one window position. That shows up at the next capture, either as a valid pulse on the wrong cycle or as a snapshot value that no longer matches the running sample total. A corrupted sample counter stays invisible until the next rollover and then appears as a wrong snapshot value, which persists in every later snapshot because the count is never cleared. Any read-induced disturbance surfaces by the following capture, at most 256 reference ticks later.

// File: rtl/srg_pkg.sv
package srg_pkg;
  localparam int unsigned SRG_REF_W  = 8;
  localparam int unsigned SRG_SMP_W  = 16;
  localparam int unsigned SRG_WORD_W = 32;
endpackage

// File: rtl/srg_ref_window.sv
module srg_ref_window #(
  parameter int unsigned REF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic             wrap_o,
  output logic [REF_W-1:0] cnt_o
);
  localparam logic [REF_W-1:0] LAST = {REF_W{1'b1}};

  function automatic logic fn_rolls(input logic [REF_W-1:0] c, input logic t);
    return t && (c == LAST);
  endfunction

  logic [REF_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign wrap_o = fn_rolls(cnt_q, tick_i);
  assign cnt_o  = cnt_q;

  AST_REF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (cnt_q == REF_W'($past(cnt_q) + 1'b1))); // R1
  AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q)); // R1
  AST_REF_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cnt_q == '0)); // R1
endmodule

// File: rtl/srg_sample_count.sv
module srg_sample_count #(
  parameter int unsigned SMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  output logic [SMP_W-1:0] cnt_o,
  output logic [SMP_W-1:0] next_o
);
  function automatic logic [SMP_W-1:0] fn_advance(input logic [SMP_W-1:0] c, input logic e);
    return c + {{(SMP_W-1){1'b0}}, e};
  endfunction

  logic [SMP_W-1:0] cnt_q;

  assign next_o = fn_advance(cnt_q, inc_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= next_o;
  end

  AST_SMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_i |=> $stable(cnt_q)); // R2
  AST_SMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    inc_i |=> (cnt_q != $past(cnt_q))); // R2
endmodule

// File: rtl/srg_snapshot.sv
module srg_snapshot #(
  parameter int unsigned SMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [SMP_W-1:0] value_i,
  output logic [SMP_W-1:0] snap_o,
  output logic             valid_o
);
  logic [SMP_W-1:0] snap_q;
  logic             valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= load_i;
      if (load_i) snap_q <= value_i;
    end
  end

  assign snap_o  = snap_q;
  assign valid_o = valid_q;

  AST_SNAP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(snap_q)); // R3
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q); // R6
endmodule

// File: rtl/srg_top.sv
module srg_top
  import srg_pkg::*;
#(
  parameter int unsigned REF_W  = SRG_REF_W,
  parameter int unsigned SMP_W  = SRG_SMP_W,
  parameter int unsigned WORD_W = SRG_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick_i,
  input  logic              smp_tick_i,
  input  logic              rd_en_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              snap_valid_o
);
  localparam int unsigned PAD_W = WORD_W - SMP_W;

  logic             ev_wrap;
  logic [REF_W-1:0] ref_cnt;
  logic [SMP_W-1:0] smp_cnt;
  logic [SMP_W-1:0] smp_next;
  logic [SMP_W-1:0] snap_val;

  srg_ref_window #(.REF_W(REF_W)) u_ref (
    .clk(clk), .rst_n(rst_n), .tick_i(ref_tick_i),
    .wrap_o(ev_wrap), .cnt_o(ref_cnt)
  );

  srg_sample_count #(.SMP_W(SMP_W)) u_smp (
    .clk(clk), .rst_n(rst_n), .inc_i(smp_tick_i),
    .cnt_o(smp_cnt), .next_o(smp_next)
  );

  srg_snapshot #(.SMP_W(SMP_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .load_i(ev_wrap), .value_i(smp_next),
    .snap_o(snap_val), .valid_o(snap_valid_o)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign rd_data_o = rd_en_i ? {{PAD_W{1'b0}}, snap_val} : '0;
    end else begin : g_nopad
      assign rd_data_o = rd_en_i ? snap_val[WORD_W-1:0] : '0;
    end
  endgenerate

  AST_CAPTURE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wrap |=> (snap_val == smp_cnt)); // R4
  AST_VALID_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wrap |=> snap_valid_o); // R6
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_wrap |=> !snap_valid_o); // R6
  always_comb begin
    if (rst_n && !rd_en_i) AST_READ_IDLE_ZERO: assert (rd_data_o == '0); // R5
  end
endmodule

// File: tb/test_srg_top.sv
`timescale 1ns/1ps
module test_srg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        smp_tick = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        snap_valid;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;

  int unsigned m_ref = 0;
  int unsigned m_smp = 0;
  int unsigned m_snap = 0;
  bit          m_valid = 1'b0;

  always #2.5 clk = ~clk;

  srg_top i_srg_top (
    .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick), .smp_tick_i(smp_tick),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .snap_valid_o(snap_valid)
  );

  function automatic logic [31:0] f_word(input int unsigned snap, input bit en);
    return en ? (snap & 32'h0000_ffff) : 32'h0;
  endfunction

  function automatic bit f_rollover(input int unsigned r, input bit t);
    return t && (r == 255);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit r, input bit s, input bit e, input string req);
    bit w;
    @(negedge clk);
    ref_tick = r; smp_tick = s; rd_en = e;
    @(posedge clk);
    w = f_rollover(m_ref, r);
    m_smp = (m_smp + s) % 65536;
    if (w) m_snap = m_smp;
    m_valid = w;
    m_ref = (m_ref + r) % 256;
    #1;
    chk(req, rd_data, f_word(m_snap, e));
    chk(req, {31'b0, snap_valid}, {31'b0, m_valid});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ref_tick = 0; smp_tick = 0; rd_en = 1'b1;
    m_ref = 0; m_smp = 0; m_snap = 0; m_valid = 0;
    #1;
    chk("R7", rd_data, 32'h0);
    chk("R7", {31'b0, snap_valid}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    // R5: idle read is zero
    step(0, 0, 0, "R5");
    // R1 R4: walk to 255 then tick both strobes in the rollover cycle
    for (int i = 0; i < 255; i++) step(1, (i % 3) == 0, 1, "R1");
    chk("R1", {31'b0, snap_valid}, 32'h0);
    step(1, 1, 1, "R4");
    chk("R4", rd_data, 32'd86);
    chk("R6", {31'b0, snap_valid}, 32'h1);
    step(0, 0, 1, "R6");
    chk("R6", {31'b0, snap_valid}, 32'h0);
    // R8: heavy read toggling through a window
    for (int i = 0; i < 600; i++) step(1, 1'($urandom_range(0, 1)), 1'(i % 2), "R8");
    // R2 R3: long random run that wraps the sample counter
    for (int i = 0; i < 90000; i++)
      step($urandom_range(0, 3) == 0, $urandom_range(0, 9) != 0,
           $urandom_range(0, 1) == 1, "R3");
    chk("R2", {31'b0, (m_smp < 32'd65536)}, 32'h1);
    // R7: reset mid-run, then first capture exactly 256 ticks later
    do_reset();
    for (int i = 0; i < 255; i++) step(1, 1, 1, "R7");
    step(1, 0, 1, "R7");
    chk("R7", rd_data, 32'd255);
    chk("R1", {31'b0, snap_valid}, 32'h1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule